// File: doc/BRIEF.md
# Auto-Incrementing Register Read Streamer

This block sits between a byte-serial transport front end and a window of 32-bit registers. The front end opens a transaction with a start index and a direction flag. It then strobes bytes one at a time and closes the transaction with an end pulse. On a read the block streams each register starting with its low byte. After the fourth byte of a word it steps to the next index, and it wraps to index zero when it passes the top of the window. Register zero always yields a fixed identification word. Once a read burst reaches its byte budget, every further byte is zero and the index stops moving.

On a write the block collects the first four bytes into a word and discards any bytes after that. When the transaction closes, it issues a single commit pulse, but only if all four bytes arrived and the index lies in the writable band. Reads and writes use separate index outputs toward the register file. This lets a status register and a control register share one address: the register file decodes the read port and the write port on their own.

Top module: `reg_read_streamer`

## Requirements
- R1: Within a read word, the first strobed byte is bits 7:0, then 15:8, then 23:16, and the last is bits 31:24.
- R2: The read index on `regRdIdx` increases by one after every fourth read byte strobe and holds still between them.
- R3: When the read index equals `WRAP_TOP` (default 0xF7) and a word completes, the next index is 0x00.
- R4: After `MAX_READ_BYTES` (default 512) strobes in one read transaction, `rdByte` is 0x00 and `regRdIdx` no longer changes until a new transaction starts.
- R5: A write transaction with four or more byte strobes produces exactly one `regWrEn` pulse. The pulse is one clock long and appears in the cycle after `txnEnd` is sampled. It carries the start index and a word in which byte k (counting from 0) sits in bits 8k+7:8k. Bytes after the fourth are ignored.
- R6: A write transaction with fewer than four byte strobes produces no `regWrEn` pulse.
- R7: A write to an index below `WR_LO` (default 0x1F) or above `WRAP_TOP` produces no `regWrEn` pulse.
- R8: A read of index 0x00 yields the bytes of 0x31505354 and does not depend on `regRdData`.
- R9: A read transaction never asserts `regWrEn`.
- R10: After reset, `rdByte` is 0x00, `regWrEn` is 0 and `regRdIdx` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | Opens a transaction, sampling `txnWrite` and `txnIdx` |
| txnWrite | input | 1 | 1 = write transaction, 0 = read transaction |
| txnIdx | input | 8 | Start register index |
| txnEnd | input | 1 | Closes the open transaction |
| byteStrobe | input | 1 | One byte transferred this cycle |
| wrByte | input | 8 | Write byte, valid with `byteStrobe` |
| rdByte | output | 8 | Read byte presented for the next strobe |
| regRdIdx | output | 8 | Register file read index |
| regRdData | input | 32 | Register file read word for `regRdIdx`, combinational |
| regWrEn | output | 1 | Register file write commit pulse |
| regWrIdx | output | 8 | Register file write index |
| regWrData | output | 32 | Register file write word |

## Verification
`regRdIdx` and `rdByte` follow a clock edge directly. After the edge that samples `txnStart` or a read strobe, the next byte is already on `rdByte` by the following falling edge. The bench therefore compares each byte at the falling edge just before it raises the next strobe. The write commit takes one register stage after the edge that samples `txnEnd`. The bench checks `regWrEn`, `regWrIdx` and `regWrData` at the next falling edge, and checks that the pulse has dropped one cycle later. A falling-edge monitor counts every commit pulse and compares the total with the number of commits the bench expects.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef struct packed {
    logic       readLive;
    logic       mute;
    logic       capture;
    logic       commit;
    logic [1:0] lane;
  } strobeT;
endpackage

// File: rtl/rrs_ctl.sv
module rrs_ctl
  import rrs_pkg::*;
#(
  parameter int               IDX_W          = 8,
  parameter logic [IDX_W-1:0] WRAP_TOP       = 8'hF7,
  parameter logic [IDX_W-1:0] WR_LO          = 8'h1F,
  parameter int               MAX_READ_BYTES = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txnStart,
  input  logic             txnWrite,
  input  logic [IDX_W-1:0] txnIdx,
  input  logic             txnEnd,
  input  logic             byteStrobe,
  output logic [IDX_W-1:0] idx,
  output strobeT           strb
);
  localparam int CNT_W = $clog2(MAX_READ_BYTES + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_READ_BYTES);
  localparam logic [2:0] WR_FULL = 3'(LANES);

  logic             active;
  logic             isWrite;
  logic [1:0]       rdLane;
  logic [2:0]       wrCnt;
  logic [CNT_W-1:0] rdCnt;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] nextIdx;
  logic             capped;
  logic             writable;

  assign capped   = (rdCnt == CAP);
  assign writable = (idxQ >= WR_LO) && (idxQ <= WRAP_TOP);
  assign nextIdx  = (idxQ == WRAP_TOP) ? '0 : idxQ + 1'b1;
  assign idx      = idxQ;

  always_comb begin
    strb.readLive = active && !isWrite;
    strb.mute     = capped;
    strb.capture  = byteStrobe && active && isWrite && (wrCnt != WR_FULL) && !txnStart;
    strb.commit   = txnEnd && active && isWrite && (wrCnt == WR_FULL) && writable;
    strb.lane     = isWrite ? wrCnt[1:0] : rdLane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
      rdLane  <= '0;
      wrCnt   <= '0;
      rdCnt   <= '0;
      idxQ    <= '0;
    end else if (txnStart) begin
      active  <= 1'b1;
      isWrite <= txnWrite;
      idxQ    <= txnIdx;
      rdLane  <= '0;
      wrCnt   <= '0;
      rdCnt   <= '0;
    end else if (txnEnd) begin
      active <= 1'b0;
    end else if (byteStrobe && active) begin
      if (isWrite) begin
        if (wrCnt != WR_FULL) wrCnt <= wrCnt + 3'd1;
      end else if (!capped) begin
        rdCnt  <= rdCnt + 1'b1;
        rdLane <= rdLane + 2'd1;
        if (rdLane == 2'd3) idxQ <= nextIdx;
      end
    end
  end
endmodule

// File: rtl/rrs_dp.sv
module rrs_dp
  import rrs_pkg::*;
#(
  parameter int                IDX_W    = 8,
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h3150_5354
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        wrByte,
  input  logic [WORD_W-1:0] regRdData,
  output logic [7:0]        rdByte,
  output logic              regWrEn,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [WORD_W-1:0] regWrData
);
  logic [WORD_W-1:0] asmWord;
  logic [WORD_W-1:0] srcWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) asmWord[g*8 +: 8] <= '0;
      else if (strb.capture && strb.lane == 2'(g)) asmWord[g*8 +: 8] <= wrByte;
    end
  end

  assign srcWord = (idx == '0) ? ID_VALUE : regRdData;

  always_comb begin
    rdByte = '0;
    if (strb.readLive && !strb.mute) begin
      for (int k = 0; k < LANES; k++) begin
        if (strb.lane == 2'(k)) rdByte = srcWord[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrIdx  <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= strb.commit;
      if (strb.commit) begin
        regWrIdx  <= idx;
        regWrData <= asmWord;
      end
    end
  end
endmodule

// File: rtl/reg_read_streamer.sv
module reg_read_streamer
  import rrs_pkg::*;
#(
  parameter int                IDX_W          = 8,
  parameter logic [IDX_W-1:0]  WRAP_TOP       = 8'hF7,
  parameter logic [IDX_W-1:0]  WR_LO          = 8'h1F,
  parameter int                MAX_READ_BYTES = 512,
  parameter logic [WORD_W-1:0] ID_VALUE       = 32'h3150_5354
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              txnWrite,
  input  logic [IDX_W-1:0]  txnIdx,
  input  logic              txnEnd,
  input  logic              byteStrobe,
  input  logic [7:0]        wrByte,
  output logic [7:0]        rdByte,
  output logic [IDX_W-1:0]  regRdIdx,
  input  logic [WORD_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [WORD_W-1:0] regWrData
);
  strobeT           strb;
  logic [IDX_W-1:0] curIdx;

  rrs_ctl #(
    .IDX_W(IDX_W), .WRAP_TOP(WRAP_TOP), .WR_LO(WR_LO), .MAX_READ_BYTES(MAX_READ_BYTES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnWrite(txnWrite), .txnIdx(txnIdx),
    .txnEnd(txnEnd), .byteStrobe(byteStrobe), .idx(curIdx), .strb(strb)
  );

  rrs_dp #(.IDX_W(IDX_W), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(curIdx), .wrByte(wrByte),
    .regRdData(regRdData), .rdByte(rdByte), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

  assign regRdIdx = curIdx;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
  import rrs_pkg::*;
#(
  parameter int               IDX_W    = 8,
  parameter logic [IDX_W-1:0] WRAP_TOP = 8'hF7,
  parameter logic [IDX_W-1:0] WR_LO    = 8'h1F
) (
  input logic             clk,
  input logic             rstN,
  input logic             txnStart,
  input logic             byteStrobe,
  input logic [IDX_W-1:0] regRdIdx,
  input logic             regWrEn,
  input logic [IDX_W-1:0] regWrIdx,
  input strobeT           strb
);
  // R5: a commit is a single-cycle pulse
  p_single_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R7: committed index lies inside the writable band
  p_wr_band_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrIdx >= WR_LO && regWrIdx <= WRAP_TOP));

  // R2: index holds without a strobe or a new transaction
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!byteStrobe && !txnStart) |=> $stable(regRdIdx));

  // R3: completing the word at the top index returns to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readLive && byteStrobe && !txnStart && !strb.mute && strb.lane == 2'd3
     && regRdIdx == WRAP_TOP) |=> (regRdIdx == '0));

  // R4: the byte budget stays spent until a new transaction
  p_cap_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mute && !txnStart) |=> strb.mute);

  // R9: reads never commit
  p_read_no_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.readLive |-> !strb.commit);
endmodule

bind reg_read_streamer rrs_checker #(
  .IDX_W(IDX_W), .WRAP_TOP(WRAP_TOP), .WR_LO(WR_LO)
) u_chk (
  .clk(clk), .rstN(rstN), .txnStart(txnStart), .byteStrobe(byteStrobe),
  .regRdIdx(regRdIdx), .regWrEn(regWrEn), .regWrIdx(regWrIdx), .strb(strb)
);

// File: tb/reg_read_streamer_tb.sv
module reg_read_streamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] TOP = 8'hF7;
  localparam logic [7:0] WLO = 8'h1F;
  localparam int CAPB = 512;
  localparam logic [31:0] IDW = 32'h3150_5354;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txnStart = 0, txnWrite = 0, txnEnd = 0, byteStrobe = 0;
  logic [7:0] txnIdx = '0, wrByte = '0;
  logic [7:0] rdByte, regRdIdx, regWrIdx;
  logic [31:0] regRdData, regWrData;
  logic regWrEn;

  int total = 0, bad = 0, seenCommits = 0, wantCommits = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] modelWord(logic [7:0] i);
    return {8'hA0 ^ i, i + 8'h11, ~i, i};
  endfunction

  function automatic logic [7:0] expByte(logic [7:0] i, int lane);
    logic [31:0] w;
    w = (i == 8'h00) ? IDW : modelWord(i);
    return w[lane*8 +: 8];
  endfunction

  function automatic logic [7:0] stepIdx(logic [7:0] i);
    return (i == TOP) ? 8'h00 : i + 8'h01;
  endfunction

  assign regRdData = modelWord(regRdIdx);

  reg_read_streamer u_dut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnWrite(txnWrite), .txnIdx(txnIdx),
    .txnEnd(txnEnd), .byteStrobe(byteStrobe), .wrByte(wrByte), .rdByte(rdByte),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

  always @(negedge clk) if (rstN && regWrEn) seenCommits++;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic openTxn(bit wr, logic [7:0] i);
    @(negedge clk);
    txnStart = 1; txnWrite = wr; txnIdx = i;
    @(negedge clk);
    txnStart = 0;
  endtask

  task automatic closeTxn();
    txnEnd = 1;
    @(negedge clk);
    txnEnd = 0;
  endtask

  // read burst; checks each byte and index before strobing it
  task automatic readBurst(logic [7:0] s, int n);
    logic [7:0] eIdx;
    int eLane, eCnt;
    eIdx = s; eLane = 0; eCnt = 0;
    openTxn(0, s);
    for (int b = 0; b < n; b++) begin
      if (eCnt >= CAPB) begin
        check(rdByte == 8'h00, "R4 byte", {24'h0, rdByte}, 32'h0);
        check(regRdIdx == eIdx, "R4 idx", {24'h0, regRdIdx}, {24'h0, eIdx});
      end else begin
        check(rdByte == expByte(eIdx, eLane), (eIdx == 0) ? "R8" : "R1",
              {24'h0, rdByte}, {24'h0, expByte(eIdx, eLane)});
        check(regRdIdx == eIdx, (eLane == 0 && eIdx == 0 && s != 0) ? "R3" : "R2",
              {24'h0, regRdIdx}, {24'h0, eIdx});
      end
      check(regWrEn == 1'b0, "R9", {31'h0, regWrEn}, 32'h0);
      byteStrobe = 1;
      @(negedge clk);
      byteStrobe = 0;
      if (eCnt < CAPB) begin
        eCnt++;
        if (eLane == 3) begin eLane = 0; eIdx = stepIdx(eIdx); end
        else eLane++;
      end
    end
    closeTxn();
    check(regWrEn == 1'b0, "R9 end", {31'h0, regWrEn}, 32'h0);
  endtask

  task automatic writeBurst(logic [7:0] i, int n, logic [31:0] w);
    bit expCommit;
    expCommit = (n >= 4) && (i >= WLO) && (i <= TOP);
    openTxn(1, i);
    for (int b = 0; b < n; b++) begin
      wrByte = (b < 4) ? w[b*8 +: 8] : 8'($urandom);
      byteStrobe = 1;
      @(negedge clk);
      byteStrobe = 0;
    end
    closeTxn();
    if (expCommit) begin
      wantCommits++;
      check(regWrEn == 1'b1, "R5 pulse", {31'h0, regWrEn}, 32'h1);
      check(regWrIdx == i, "R5 idx", {24'h0, regWrIdx}, {24'h0, i});
      check(regWrData == w, "R5 data", regWrData, w);
    end else begin
      check(regWrEn == 1'b0, (n < 4) ? "R6" : "R7", {31'h0, regWrEn}, 32'h0);
    end
    @(negedge clk);
    check(regWrEn == 1'b0, "R5 width", {31'h0, regWrEn}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(rdByte == 8'h00, "R10 rdByte", {24'h0, rdByte}, 32'h0);
    check(regWrEn == 1'b0, "R10 regWrEn", {31'h0, regWrEn}, 32'h0);
    check(regRdIdx == 8'h00, "R10 regRdIdx", {24'h0, regRdIdx}, 32'h0);
    rstN = 1;
    @(negedge clk);

    readBurst(8'h00, 8);              // R8 then R1/R2
    readBurst(8'h21, 6);              // partial word
    readBurst(8'hF6, 12);             // R3 wrap
    readBurst(8'h40, CAPB + 9);       // R4 budget
    writeBurst(8'h30, 4, 32'hDEAD_BEEF);  // R5
    writeBurst(8'h1F, 7, 32'h0102_0304);  // R5 extra bytes ignored
    writeBurst(8'hF7, 4, 32'h5555_AAAA);  // R5 top of band
    writeBurst(8'h44, 3, 32'h1234_5678);  // R6
    writeBurst(8'h44, 0, 32'h0);          // R6
    writeBurst(8'h05, 4, 32'hCAFE_0001);  // R7 read-only
    writeBurst(8'h1E, 4, 32'hCAFE_0002);  // R7 edge
    writeBurst(8'hF9, 5, 32'hCAFE_0003);  // R7 reserved

    for (int t = 0; t < 30; t++) begin
      if ($urandom_range(1, 0) == 1)
        writeBurst(8'($urandom_range(255, 0)), int'($urandom_range(8, 0)), $urandom);
      else
        readBurst(8'($urandom_range(247, 0)), int'($urandom_range(20, 1)));
    end

    repeat (2) @(negedge clk);
    check(seenCommits == wantCommits, "R5 count", seenCommits, wantCommits);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule